// File: doc/BRIEF.md
# Two-Channel Sticky Status Word

This block holds the 16-bit status word of a two-channel I/O controller. Each cycle it takes the raw status events of two primary channels and passes each one through a per-channel enable mask. It also takes the raw status of two secondary channels and the contents of a supervisor register, and reduces each of these two groups to a single summary flag. Every gated event and both summaries are latched as sticky bits. The latched word drives the output directly.

The host reads the word by raising a one-cycle read strobe and sampling `stat_word` in that same cycle. The latched contents are cleared on the following clock edge. The host-side serial interface, the opcode decoding, the spike filter and the overcurrent detection all sit outside the block and feed it event vectors. Interrupt generation also sits outside.

Top module: `chstat_agg`

## Requirements
- R1: During and after a synchronous reset (`rst` high at a rising edge), `stat_word` is 16'h0000.
- R2: Word layout: bits 6:0 carry channel-1 status bits 6:0, bit 7 the secondary summary, bits 14:8 channel-2 status bits 6:0, and bit 15 the supervisor summary.
- R3: Channel status bit 0 is governed by enable bit 0 and status bit 1 by enable bit 1. An event on such a bit while its enable bit is 0 leaves the status bit at 0.
- R4: Enable bit 2 of a channel governs status bits 2 to 6 of that channel together. Each of those five bits latches only its own event.
- R5: Bit 7 is set on the edge after any bit of `sec1_stat` or `sec2_stat` is 1.
- R6: Bit 15 is set on the edge after any bit of `spv_stat` is 1.
- R7: A set bit stays set while `rd_stb` is low, even after its source returns to 0.
- R8: On the edge after `rd_stb` is high, every bit that has no enabled event in the strobe cycle becomes 0.
- R9: An enabled event present in the same cycle as `rd_stb` is set after the clear.
- R10: In the cycle where `rd_stb` is high, `stat_word` still shows the contents latched before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch1_evt | input | 7 | Raw status events, primary channel 1 |
| ch2_evt | input | 7 | Raw status events, primary channel 2 |
| ch1_en | input | 3 | Enable mask, channel 1 (bit 2 shared by status bits 2..6) |
| ch2_en | input | 3 | Enable mask, channel 2 (bit 2 shared by status bits 2..6) |
| sec1_stat | input | SEC_W | Status of secondary channel 1 |
| sec2_stat | input | SEC_W | Status of secondary channel 2 |
| spv_stat | input | SPV_W | Supervisor register contents |
| rd_stb | input | 1 | Read strobe; the word clears on the following edge |
| stat_word | output | 16 | Latched status word |

## Verification
The state of this block is the output word itself, so a bit that is set or cleared wrongly is visible at `stat_word` one edge after the stimulus that caused it. If the enable mapping is wrong, a disabled event sets a bit or a shared-group event lands in the wrong position. If the clear is wrong, bits survive a read, or a coincident event disappears on the edge after the strobe. The directed scenarios drive each of these cases and check the word in the cycle the error would first appear.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

    // Per-channel status layout
    localparam int CH_BITS  = 7;
    localparam int GROUP_LO = 2;               // first bit of the shared-enable group
    localparam int EN_W     = GROUP_LO + 1;    // individual enables + one group enable
    localparam int WORD_W   = 2 * CH_BITS + 2;

    typedef logic [CH_BITS-1:0] ch_vec_t;
    typedef logic [EN_W-1:0]    ch_en_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Packed from MSB down: supervisor summary, channel 2, secondary summary, channel 1
    typedef struct packed {
        logic    spv_sum;
        ch_vec_t ch2;
        logic    sec_sum;
        ch_vec_t ch1;
    } stat_word_s;

    // Map an enable register onto per-status-bit enables
    function automatic ch_vec_t expand_en(input ch_en_t en);
        ch_vec_t m;
        for (int i = 0; i < CH_BITS; i++) begin
            m[i] = (i < GROUP_LO) ? en[i] : en[GROUP_LO];
        end
        return m;
    endfunction

endpackage

// File: rtl/chstat_mask.sv
module chstat_mask
    import chstat_pkg::*;
(
    input  ch_en_t  en,
    input  ch_vec_t evt,
    output ch_vec_t gated
);

    ch_vec_t bit_en;

    assign bit_en = expand_en(en);

    for (genvar i = 0; i < CH_BITS; i++) begin : g_bit
        assign gated[i] = evt[i] & bit_en[i];
    end

endmodule

// File: rtl/chstat_summary.sv
module chstat_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    output logic         hit
);

    assign hit = |src;

endmodule

// File: rtl/chstat_sticky.sv
module chstat_sticky #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q <= set;          // a clearing read keeps events of the same cycle
        end else begin
            q <= q | set;
        end
    end

endmodule

// File: rtl/chstat_agg.sv
module chstat_agg
    import chstat_pkg::*;
#(
    parameter int SEC_W = 7,
    parameter int SPV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       ch1_evt,
    input  logic [6:0]       ch2_evt,
    input  logic [2:0]       ch1_en,
    input  logic [2:0]       ch2_en,
    input  logic [SEC_W-1:0] sec1_stat,
    input  logic [SEC_W-1:0] sec2_stat,
    input  logic [SPV_W-1:0] spv_stat,
    input  logic             rd_stb,
    output logic [15:0]      stat_word
);

    localparam int NCH = 2;

    ch_vec_t    evt_arr   [NCH];
    ch_en_t     en_arr    [NCH];
    ch_vec_t    gated_arr [NCH];
    logic       sec_hit;
    logic       spv_hit;
    stat_word_s ev_now;
    word_t      latched;

    assign evt_arr[0] = ch1_evt;
    assign evt_arr[1] = ch2_evt;
    assign en_arr[0]  = ch1_en;
    assign en_arr[1]  = ch2_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chstat_mask u_mask (
            .en    (en_arr[c]),
            .evt   (evt_arr[c]),
            .gated (gated_arr[c])
        );
    end

    chstat_summary #(.W(2 * SEC_W)) u_sec_sum (
        .src ({sec2_stat, sec1_stat}),
        .hit (sec_hit)
    );

    chstat_summary #(.W(SPV_W)) u_spv_sum (
        .src (spv_stat),
        .hit (spv_hit)
    );

    always_comb begin
        ev_now.ch1     = gated_arr[0];
        ev_now.sec_sum = sec_hit;
        ev_now.ch2     = gated_arr[1];
        ev_now.spv_sum = spv_hit;
    end

    chstat_sticky #(.W(WORD_W)) u_sticky (
        .clk (clk),
        .rst (rst),
        .clr (rd_stb),
        .set (ev_now),
        .q   (latched)
    );

    assign stat_word = latched;

endmodule

// File: rtl/chstat_agg_chk.sv
module chstat_agg_chk #(
    parameter int SEC_W = 7,
    parameter int SPV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       ch1_evt,
    input logic [6:0]       ch2_evt,
    input logic [2:0]       ch1_en,
    input logic [2:0]       ch2_en,
    input logic [SEC_W-1:0] sec1_stat,
    input logic [SEC_W-1:0] sec2_stat,
    input logic [SPV_W-1:0] spv_stat,
    input logic             rd_stb,
    input logic [15:0]      stat_word
);

    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: word is zero after a reset edge
    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_zero_R1: assert (stat_word == 16'h0000);
        end
    end

    assert_ch1_bit0_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (!ch1_en[0] && !stat_word[0]) |=> !stat_word[0]);

    assert_ch2_bit1_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (!ch2_en[1] && !stat_word[9]) |=> !stat_word[9]);

    assert_group_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!ch1_en[2] && stat_word[6:2] == 5'd0) |=> (stat_word[6:2] == 5'd0));

    assert_sec_summary_R5: assert property (@(posedge clk) disable iff (rst)
        ((|sec1_stat) || (|sec2_stat)) |=> stat_word[7]);

    assert_spv_summary_R6: assert property (@(posedge clk) disable iff (rst)
        (|spv_stat) |=> stat_word[15]);

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((stat_word & $past(stat_word)) == $past(stat_word)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ch1_evt == 7'd0 && ch2_evt == 7'd0 &&
         sec1_stat == '0 && sec2_stat == '0 && spv_stat == '0)
        |=> (stat_word == 16'h0000));

    assert_collide_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ch1_en[0] && ch1_evt[0]) |=> stat_word[0]);

endmodule

bind chstat_agg chstat_agg_chk #(.SEC_W(SEC_W), .SPV_W(SPV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch1_evt   (ch1_evt),
    .ch2_evt   (ch2_evt),
    .ch1_en    (ch1_en),
    .ch2_en    (ch2_en),
    .sec1_stat (sec1_stat),
    .sec2_stat (sec2_stat),
    .spv_stat  (spv_stat),
    .rd_stb    (rd_stb),
    .stat_word (stat_word)
);

// File: tb/chstat_agg_tb.sv
module chstat_agg_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  ch1_evt, ch2_evt;
    logic [2:0]  ch1_en, ch2_en;
    logic [6:0]  sec1_stat, sec2_stat;
    logic [7:0]  spv_stat;
    logic        rd_stb;
    logic [15:0] stat_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    chstat_agg u_dut (
        .clk       (clk),
        .rst       (rst),
        .ch1_evt   (ch1_evt),
        .ch2_evt   (ch2_evt),
        .ch1_en    (ch1_en),
        .ch2_en    (ch2_en),
        .sec1_stat (sec1_stat),
        .sec2_stat (sec2_stat),
        .spv_stat  (spv_stat),
        .rd_stb    (rd_stb),
        .stat_word (stat_word)
    );

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (stat_word !== exp) begin
            n_fail++;
            $display("FAIL %s: stat_word=%h expected=%h", req, stat_word, exp);
        end
    endtask

    task automatic idle_inputs();
        ch1_evt = '0; ch2_evt = '0; sec1_stat = '0; sec2_stat = '0;
        spv_stat = '0; rd_stb = 1'b0;
    endtask

    // Present events for one cycle; on return (next negedge) inputs are idle
    task automatic pulse(input logic [6:0] e1, input logic [6:0] e2,
                         input logic [6:0] s1, input logic [6:0] s2,
                         input logic [7:0] sp);
        @(negedge clk);
        ch1_evt = e1; ch2_evt = e2; sec1_stat = s1; sec2_stat = s2; spv_stat = sp;
        @(negedge clk);
        idle_inputs();
    endtask

    // Read: value in strobe cycle is pre-clear (R10), zero afterwards (R8)
    task automatic read_clear(input logic [15:0] exp);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 check("R10", exp);
        @(negedge clk);
        rd_stb = 1'b0;
        check("R8", 16'h0000);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        ch1_en = 3'b111; ch2_en = 3'b111;
        ch1_evt = 7'h7F;
        repeat (2) @(negedge clk);
        check("R1", 16'h0000);
        rst = 1'b0;
        ch1_evt = '0;
        @(negedge clk);
        check("R1", 16'h0000);
    endtask

    task automatic t_layout();
        ch1_en = 3'b111; ch2_en = 3'b111;
        pulse(7'h01, 7'h00, 7'h00, 7'h00, 8'h00);
        check("R2", 16'h0001);
        read_clear(16'h0001);
        pulse(7'h00, 7'h01, 7'h00, 7'h00, 8'h00);
        check("R2", 16'h0100);
        read_clear(16'h0100);
        pulse(7'h7F, 7'h7F, 7'h40, 7'h00, 8'h80);
        check("R2", 16'hFFFF);
        read_clear(16'hFFFF);
    endtask

    task automatic t_enable();
        ch1_en = 3'b000; ch2_en = 3'b000;
        pulse(7'h7F, 7'h7F, 7'h00, 7'h00, 8'h00);
        check("R3", 16'h0000);
        ch1_en = 3'b011; ch2_en = 3'b010;
        pulse(7'h7F, 7'h7F, 7'h00, 7'h00, 8'h00);
        check("R3", 16'h0203);
        read_clear(16'h0203);
    endtask

    task automatic t_group();
        ch1_en = 3'b000; ch2_en = 3'b100;
        pulse(7'h00, 7'b0100100, 7'h00, 7'h00, 8'h00);
        check("R4", 16'h2400);
        pulse(7'h00, 7'b1000011, 7'h00, 7'h00, 8'h00);
        check("R4", 16'h6400);
        read_clear(16'h6400);
    endtask

    task automatic t_summaries();
        pulse(7'h00, 7'h00, 7'h00, 7'h10, 8'h00);
        check("R5", 16'h0080);
        read_clear(16'h0080);
        pulse(7'h00, 7'h00, 7'h01, 7'h00, 8'h00);
        check("R5", 16'h0080);
        read_clear(16'h0080);
        pulse(7'h00, 7'h00, 7'h00, 7'h00, 8'h04);
        check("R6", 16'h8000);
        read_clear(16'h8000);
    endtask

    task automatic t_sticky();
        ch1_en = 3'b111; ch2_en = 3'b111;
        pulse(7'h02, 7'h00, 7'h00, 7'h00, 8'h00);
        repeat (3) @(negedge clk);
        check("R7", 16'h0002);
        pulse(7'h00, 7'h08, 7'h00, 7'h00, 8'h00);
        check("R7", 16'h0802);
        read_clear(16'h0802);
    endtask

    task automatic t_collide();
        ch1_en = 3'b111;
        pulse(7'h01, 7'h00, 7'h00, 7'h00, 8'h00);
        @(negedge clk);
        rd_stb = 1'b1;
        ch1_evt = 7'h08;
        spv_stat = 8'h01;
        #1 check("R10", 16'h0001);
        @(negedge clk);
        idle_inputs();
        check("R9", 16'h8008);
        read_clear(16'h8008);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_enable();
        t_group();
        t_summaries();
        t_sticky();
        t_collide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule